// File: doc/BRIEF.md
# Custom-Operation Configuration Manager

This block sits beside the decode stage of a processor that carries a reconfigurable execution array. It recognises custom-operation instruction words and keeps a directory of the operations whose configurations are loaded in the array. For each loaded operation, the directory holds the operation ID, the base row, the row count and the bitmap of source registers that the operation reads. On a hit, the block reports the base row, the source bitmap and the destination register in the same cycle.

On a miss, the block stalls the pipeline. It reads the operation's image pointer from a per-ID pointer table and fetches the source bitmap and the row count. It then finds a run of free array rows and streams the row configuration words from memory, writing each assembled row into the array. When no run of free rows is long enough, or no directory slot is free, the least recently used operations are evicted one at a time until the new operation fits.

A snoop port watches stores. Any store into the configuration address window raises a one-cycle exception and empties the directory in that cycle. If a load is in progress when this happens, the load is abandoned.

Top module: `cfgmgr_top`

## Requirements
- R1: An instruction is a custom operation when bits [31:22] equal the `OP_CODE` parameter. Bits [21:17] give the destination register, reported on `dst_o`, and bits [16:0] give the operation ID. Any other opcode produces neither a hit nor a stall.
- R2: When a valid custom operation names a resident ID, `hit_o` is 1 in that cycle, `stall_o` is 0, and `row_base_o` and `src_vec_o` show that operation's base row and source bitmap.
- R3: When a valid custom operation names an ID that is not resident, `stall_o` is 1 in that cycle. It stays 1 until the configuration has been fully written, after which the same instruction hits.
- R4: A load makes single-word reads in this order: the pointer at `VTAB_BASE + 4*ID`, then the source bitmap at the pointer, then the row count at pointer+4, then the row words at consecutive addresses from pointer+8. `mem_req_o` and `mem_addr_o` are held until `mem_rvalid_i` is returned.
- R5: Each row takes 53 words. Word k fills row bits [32k+31:32k]. Only the low 10 bits of the final word are kept, which gives 1674 bits per row. Once a row is complete, `row_we_o` pulses for one cycle with `row_idx_o` = base + row number and `row_data_o` = the assembled row.
- R6: A new configuration is placed at the lowest base row where it fits in free rows. An occupied run of rows never crosses row `NUM_ROWS`-1.
- R7: When the new configuration does not fit, the resident operation that was used least recently, counting both hits and loads, is evicted. This repeats until the configuration fits, and operations that remain resident keep their rows.
- R8: A valid snoop address inside [`CFG_LO`, `CFG_HI`] raises `exc_o` for exactly one cycle, beginning in the cycle after the snoop. In the cycle of the snoop, every resident entry is invalidated. A snoop address outside that window has no effect.
- R9: After reset, `stall_o`, `hit_o`, `exc_o`, `row_we_o` and `mem_req_o` are 0 and no operation is resident.
- R10: An operation ID is resident at most once, and no two resident operations share a row. Issuing an ID that is already resident causes no memory reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | Instruction word valid |
| instr_i | input | 32 | Instruction word |
| stall_o | output | 1 | Pipeline stall |
| hit_o | output | 1 | Operation resident and ready |
| row_base_o | output | 5 | Base row of the hit operation |
| src_vec_o | output | 32 | Source-register bitmap of the hit operation |
| dst_o | output | 5 | Destination register field of the instruction |
| mem_req_o | output | 1 | Memory read request, held until data returns |
| mem_addr_o | output | 32 | Memory read byte address |
| mem_rvalid_i | input | 1 | Read data valid; completes the request |
| mem_rdata_i | input | 32 | Read data |
| snoop_valid_i | input | 1 | Snooped store valid |
| snoop_addr_i | input | 32 | Snooped store address |
| exc_o | output | 1 | Configuration-space write exception |
| row_we_o | output | 1 | Array row write strobe |
| row_idx_o | output | 5 | Array row being written |
| row_data_o | output | 1674 | Array row configuration bits |

## Verification
The assertions check the directory's integrity on every cycle. They confirm that at most one slot matches an ID, that the row ranges of resident operations never overlap, and that a hit entry lies within the array. They also confirm that a flush leaves no valid slot, that a pending memory request keeps its address until the data returns, that row strobes are never issued back to back, and that no hit is reported during an exception cycle. Other behaviour can only be shown by the directed scenarios: the order of the load's reads, the bit placement inside a row, the truncation of the final word, first-fit placement, and which operation least-recently-used eviction selects after a hit changes the recency order.

// File: rtl/cfgmgr_pkg.sv
package cfgmgr_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 10;
  localparam int DST_W   = 5;
  localparam int OPID_W  = 17;
  localparam int WORD_W  = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PTR, ST_VEC, ST_CNT, ST_ALLOC, ST_ROWS, ST_DRAIN
  } ld_state_e;
endpackage

// File: rtl/cfgmgr_dir.sv
module cfgmgr_dir import cfgmgr_pkg::*; #(
  parameter int NUM_ROWS  = 32,
  parameter int NUM_SLOTS = 32,
  localparam int ROW_W  = $clog2(NUM_ROWS),
  localparam int CNT_W  = $clog2(NUM_ROWS + 1),
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OPID_W-1:0] lk_id_i,
  output logic              lk_hit_o,
  output logic [ROW_W-1:0]  lk_base_o,
  output logic [WORD_W-1:0] lk_vec_o,
  input  logic              touch_en_i,
  input  logic [CNT_W-1:0]  need_i,
  output logic              fit_ok_o,
  output logic [ROW_W-1:0]  fit_base_o,
  output logic              free_ok_o,
  output logic [SLOT_W-1:0] free_slot_o,
  input  logic              evict_en_i,
  input  logic              alloc_en_i,
  input  logic [SLOT_W-1:0] alloc_slot_i,
  input  logic [OPID_W-1:0] alloc_id_i,
  input  logic [WORD_W-1:0] alloc_vec_i,
  input  logic [ROW_W-1:0]  alloc_base_i,
  input  logic [CNT_W-1:0]  alloc_cnt_i,
  input  logic              flush_i
);
  logic [NUM_SLOTS-1:0] valid_q;
  logic [SLOT_W-1:0]    age_q  [NUM_SLOTS];
  logic [OPID_W-1:0]    id_q   [NUM_SLOTS];
  logic [WORD_W-1:0]    vec_q  [NUM_SLOTS];
  logic [ROW_W-1:0]     base_q [NUM_SLOTS];
  logic [CNT_W-1:0]     cnt_q  [NUM_SLOTS];

  logic [NUM_SLOTS-1:0] match;
  logic [SLOT_W-1:0]    lk_slot, victim;
  logic [CNT_W-1:0]     lk_cnt;
  logic [NUM_ROWS-1:0]  used;
  logic                 overlap;

  always_comb begin
    lk_hit_o  = 1'b0;
    lk_slot   = '0;
    lk_base_o = '0;
    lk_vec_o  = '0;
    lk_cnt    = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      match[s] = valid_q[s] && (id_q[s] == lk_id_i);
      if (match[s]) begin
        lk_hit_o  = 1'b1;
        lk_slot   = SLOT_W'(s);
        lk_base_o = base_q[s];
        lk_vec_o  = vec_q[s];
        lk_cnt    = cnt_q[s];
      end
    end
  end

  // row occupancy, then lowest base with a long enough free run
  always_comb begin
    logic ok;
    used    = '0;
    overlap = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (valid_q[s])
        for (int j = 0; j < NUM_ROWS; j++)
          if (j >= int'(base_q[s]) && j < int'(base_q[s]) + int'(cnt_q[s])) begin
            if (used[j]) overlap = 1'b1;
            used[j] = 1'b1;
          end
    fit_ok_o   = 1'b0;
    fit_base_o = '0;
    for (int b = 0; b < NUM_ROWS; b++) begin
      ok = (b + int'(need_i) <= NUM_ROWS);
      for (int j = 0; j < NUM_ROWS; j++)
        if (j >= b && j < b + int'(need_i) && used[j]) ok = 1'b0;
      if (ok && !fit_ok_o) begin
        fit_ok_o   = 1'b1;
        fit_base_o = ROW_W'(b);
      end
    end
  end

  always_comb begin
    logic have;
    free_ok_o   = 1'b0;
    free_slot_o = '0;
    victim      = '0;
    have        = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (!valid_q[s] && !free_ok_o) begin
        free_ok_o   = 1'b1;
        free_slot_o = SLOT_W'(s);
      end
      if (valid_q[s] && (!have || age_q[s] > age_q[victim])) begin
        have   = 1'b1;
        victim = SLOT_W'(s);
      end
    end
  end

  // recency ranks: 0 = most recent, victim = highest rank
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int s = 0; s < NUM_SLOTS; s++) age_q[s] <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else begin
      if (evict_en_i) valid_q[victim] <= 1'b0;
      if (alloc_en_i) begin
        for (int s = 0; s < NUM_SLOTS; s++)
          if (valid_q[s] && SLOT_W'(s) != alloc_slot_i) age_q[s] <= age_q[s] + 1'b1;
        valid_q[alloc_slot_i] <= 1'b1;
        age_q[alloc_slot_i]   <= '0;
      end
      if (touch_en_i) begin
        for (int s = 0; s < NUM_SLOTS; s++)
          if (valid_q[s] && age_q[s] < age_q[lk_slot]) age_q[s] <= age_q[s] + 1'b1;
        age_q[lk_slot] <= '0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_en_i) begin
      id_q[alloc_slot_i]   <= alloc_id_i;
      vec_q[alloc_slot_i]  <= alloc_vec_i;
      base_q[alloc_slot_i] <= alloc_base_i;
      cnt_q[alloc_slot_i]  <= alloc_cnt_i;
    end
  end

  // R10
  uniq_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(match));
  // R10
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !overlap);
  // R6
  hit_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (int'(lk_base_o) + int'(lk_cnt) <= NUM_ROWS));
  // R8
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));
endmodule

// File: rtl/cfgmgr_rowasm.sv
module cfgmgr_rowasm import cfgmgr_pkg::*; #(
  parameter int ROW_BITS = 1674,
  localparam int WPR    = (ROW_BITS + WORD_W - 1) / WORD_W,
  localparam int IDX_W  = $clog2(WPR),
  localparam int LAST_W = ROW_BITS - (WPR - 1) * WORD_W
) (
  input  logic                clk_i,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [WORD_W-1:0]   word_i,
  output logic [ROW_BITS-1:0] row_o
);
  for (genvar g = 0; g < WPR; g++) begin : g_seg
    if (g < WPR - 1) begin : g_full
      logic [WORD_W-1:0] seg_q;
      always_ff @(posedge clk_i)
        if (we_i && idx_i == IDX_W'(g)) seg_q <= word_i;
      assign row_o[g*WORD_W +: WORD_W] = seg_q;
    end else begin : g_tail
      logic [LAST_W-1:0] seg_q;
      always_ff @(posedge clk_i)
        if (we_i && idx_i == IDX_W'(g)) seg_q <= word_i[LAST_W-1:0];
      assign row_o[ROW_BITS-1 -: LAST_W] = seg_q;
    end
  end
endmodule

// File: rtl/cfgmgr_top.sv
module cfgmgr_top import cfgmgr_pkg::*; #(
  parameter int          NUM_ROWS  = 32,
  parameter int          NUM_SLOTS = 32,
  parameter int          ROW_BITS  = 1674,
  parameter logic [9:0]  OP_CODE   = 10'h3A5,
  parameter logic [31:0] VTAB_BASE = 32'h0000_1000,
  parameter logic [31:0] CFG_LO    = 32'h0001_0000,
  parameter logic [31:0] CFG_HI    = 32'h0003_FFFF,
  localparam int ROW_W  = $clog2(NUM_ROWS),
  localparam int CNT_W  = $clog2(NUM_ROWS + 1),
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int WPR    = (ROW_BITS + WORD_W - 1) / WORD_W,
  localparam int IDX_W  = $clog2(WPR)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                instr_valid_i,
  input  logic [INSTR_W-1:0]  instr_i,
  output logic                stall_o,
  output logic                hit_o,
  output logic [ROW_W-1:0]    row_base_o,
  output logic [WORD_W-1:0]   src_vec_o,
  output logic [DST_W-1:0]    dst_o,
  output logic                mem_req_o,
  output logic [31:0]         mem_addr_o,
  input  logic                mem_rvalid_i,
  input  logic [WORD_W-1:0]   mem_rdata_i,
  input  logic                snoop_valid_i,
  input  logic [31:0]         snoop_addr_i,
  output logic                exc_o,
  output logic                row_we_o,
  output logic [ROW_W-1:0]    row_idx_o,
  output logic [ROW_BITS-1:0] row_data_o
);
  ld_state_e         state_q;
  logic [OPID_W-1:0] ld_id_q;
  logic [31:0]       addr_q;
  logic [WORD_W-1:0] vec_q;
  logic [CNT_W-1:0]  cnt_q, cnt_clamp;
  logic [ROW_W-1:0]  base_q;
  logic [SLOT_W-1:0] slot_q;
  logic [CNT_W-1:0]  row_q;
  logic [IDX_W-1:0]  word_q;

  logic              is_op, lk_hit, fit_ok, free_ok, snoop_hit, xfer;
  logic              last_word, last_row, evict_en, alloc_en;
  logic [OPID_W-1:0] req_id;
  logic [ROW_W-1:0]  lk_base, fit_base;
  logic [WORD_W-1:0] lk_vec;
  logic [SLOT_W-1:0] free_slot;

  assign is_op     = instr_i[31 -: OPC_W] == OP_CODE;
  assign dst_o     = instr_i[OPID_W +: DST_W];
  assign req_id    = instr_i[OPID_W-1:0];
  assign snoop_hit = snoop_valid_i && snoop_addr_i >= CFG_LO && snoop_addr_i <= CFG_HI;

  assign mem_req_o  = state_q inside {ST_PTR, ST_VEC, ST_CNT, ST_ROWS, ST_DRAIN};
  assign mem_addr_o = addr_q;
  assign xfer       = mem_req_o && mem_rvalid_i;
  assign last_word  = word_q == IDX_W'(WPR - 1);
  assign last_row   = row_q == cnt_q - 1'b1;
  assign evict_en   = state_q == ST_ALLOC && !(fit_ok && free_ok) && !snoop_hit;
  assign alloc_en   = state_q == ST_ROWS && xfer && last_word && last_row && !snoop_hit;

  assign hit_o      = instr_valid_i && is_op && lk_hit && state_q == ST_IDLE;
  assign stall_o    = (instr_valid_i && is_op && !hit_o) || state_q != ST_IDLE;
  assign row_base_o = lk_base;
  assign src_vec_o  = lk_vec;

  // row count forced into 1..NUM_ROWS
  always_comb begin
    if (mem_rdata_i == '0)                  cnt_clamp = CNT_W'(1);
    else if (mem_rdata_i > WORD_W'(NUM_ROWS)) cnt_clamp = CNT_W'(NUM_ROWS);
    else                                      cnt_clamp = mem_rdata_i[CNT_W-1:0];
  end

  cfgmgr_dir #(.NUM_ROWS(NUM_ROWS), .NUM_SLOTS(NUM_SLOTS)) u_dir (
    .clk_i, .rst_ni,
    .lk_id_i(req_id), .lk_hit_o(lk_hit), .lk_base_o(lk_base), .lk_vec_o(lk_vec),
    .touch_en_i(hit_o), .need_i(cnt_q),
    .fit_ok_o(fit_ok), .fit_base_o(fit_base), .free_ok_o(free_ok), .free_slot_o(free_slot),
    .evict_en_i(evict_en), .alloc_en_i(alloc_en), .alloc_slot_i(slot_q),
    .alloc_id_i(ld_id_q), .alloc_vec_i(vec_q), .alloc_base_i(base_q), .alloc_cnt_i(cnt_q),
    .flush_i(snoop_hit)
  );

  cfgmgr_rowasm #(.ROW_BITS(ROW_BITS)) u_asm (
    .clk_i, .we_i(state_q == ST_ROWS && xfer), .idx_i(word_q),
    .word_i(mem_rdata_i), .row_o(row_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ld_id_q   <= '0;
      addr_q    <= '0;
      vec_q     <= '0;
      cnt_q     <= CNT_W'(1);
      base_q    <= '0;
      slot_q    <= '0;
      row_q     <= '0;
      word_q    <= '0;
      exc_o     <= 1'b0;
      row_we_o  <= 1'b0;
      row_idx_o <= '0;
    end else begin
      exc_o    <= snoop_hit;
      row_we_o <= 1'b0;
      if (snoop_hit) begin
        // abandon load; an outstanding read must still be drained
        state_q <= (mem_req_o && !mem_rvalid_i) ? ST_DRAIN : ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (instr_valid_i && is_op && !lk_hit) begin
            ld_id_q <= req_id;
            addr_q  <= VTAB_BASE + {13'd0, req_id, 2'b00};
            state_q <= ST_PTR;
          end
          ST_PTR: if (xfer) begin
            addr_q  <= mem_rdata_i;
            state_q <= ST_VEC;
          end
          ST_VEC: if (xfer) begin
            vec_q   <= mem_rdata_i;
            addr_q  <= addr_q + 32'd4;
            state_q <= ST_CNT;
          end
          ST_CNT: if (xfer) begin
            cnt_q   <= cnt_clamp;
            addr_q  <= addr_q + 32'd4;
            state_q <= ST_ALLOC;
          end
          ST_ALLOC: if (fit_ok && free_ok) begin
            base_q  <= fit_base;
            slot_q  <= free_slot;
            row_q   <= '0;
            word_q  <= '0;
            state_q <= ST_ROWS;
          end
          ST_ROWS: if (xfer) begin
            addr_q <= addr_q + 32'd4;
            if (last_word) begin
              word_q    <= '0;
              row_we_o  <= 1'b1;
              row_idx_o <= base_q + ROW_W'(row_q);
              if (last_row) state_q <= ST_IDLE;
              else          row_q   <= row_q + 1'b1;
            end else begin
              word_q <= word_q + 1'b1;
            end
          end
          ST_DRAIN: if (mem_rvalid_i) state_q <= ST_IDLE;
          default:  state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R5
  row_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_we_o |=> !row_we_o);
  // R8
  exc_nohit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> !hit_o);
endmodule

// File: tb/cfgmgr_top_tb.sv
module cfgmgr_top_tb;
  localparam int          ROW_BITS = 1674;
  localparam int          WPR      = 53;
  localparam logic [9:0]  OPC      = 10'h3A5;
  localparam logic [31:0] VTAB     = 32'h0000_1000;
  localparam logic [31:0] CLO      = 32'h0001_0000;

  logic                clk = 0, rst_n = 0;
  logic                instr_valid = 0;
  logic [31:0]         instr = '0;
  logic                stall_o, hit_o, mem_req_o, exc_o, row_we_o;
  logic [4:0]          row_base_o, dst_o, row_idx_o;
  logic [31:0]         src_vec_o, mem_addr_o, snoop_addr = '0;
  logic                mem_rvalid = 0, snoop_valid = 0;
  logic [31:0]         mem_rdata = '0;
  logic [ROW_BITS-1:0] row_data_o;

  int n_chk = 0, n_fail = 0;
  int nlog = 0, nrows = 0, first_idx = -1, last_idx = -1;
  logic [31:0]         alog [8];
  logic [ROW_BITS-1:0] row0;

  always #5 clk = ~clk;

  cfgmgr_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(instr_valid), .instr_i(instr),
    .stall_o, .hit_o, .row_base_o, .src_vec_o, .dst_o,
    .mem_req_o, .mem_addr_o, .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .snoop_valid_i(snoop_valid), .snoop_addr_i(snoop_addr),
    .exc_o, .row_we_o, .row_idx_o, .row_data_o
  );

  function automatic logic [31:0] ptr_of(int id); return CLO + 32'(id) * 32'h2000; endfunction
  function automatic logic [31:0] vec_of(int id); return (32'h1 << id) | 32'h8000_0000; endfunction
  function automatic logic [31:0] cnt_of(int id);
    case (id)
      5: return 4;  9: return 10; 3: return 18;
      7: return 8;  2: return 2;  4: return 6;
      default: return 1;
    endcase
  endfunction
  function automatic logic [31:0] pat(logic [31:0] a); return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F; endfunction

  function automatic logic [31:0] mem_word(logic [31:0] a);
    int id; logic [31:0] off;
    if (a >= VTAB && a < VTAB + 32'h100) return ptr_of(int'((a - VTAB) >> 2));
    id  = int'((a - CLO) >> 13);
    off = (a - CLO) & 32'h1FFF;
    if (off == 0) return vec_of(id);
    if (off == 4) return cnt_of(id);
    return pat(a);
  endfunction

  function automatic logic [ROW_BITS-1:0] exp_row(int id, int r);
    logic [WPR*32-1:0] t;
    for (int k = 0; k < WPR; k++)
      t[k*32 +: 32] = pat(ptr_of(id) + 32'd8 + 32'(4 * (r * WPR + k)));
    return t[ROW_BITS-1:0];
  endfunction

  // memory responder: one read in flight, answered half a cycle after it is seen
  initial forever begin
    @(negedge clk);
    if (mem_req_o && !mem_rvalid) begin
      mem_rvalid = 1;
      mem_rdata  = mem_word(mem_addr_o);
      if (nlog < 8) alog[nlog] = mem_addr_o;
      nlog++;
    end else mem_rvalid = 0;
  end

  // row write monitor
  initial forever begin
    @(negedge clk);
    if (row_we_o) begin
      if (nrows == 0) begin first_idx = int'(row_idx_o); row0 = row_data_o; end
      last_idx = int'(row_idx_o);
      nrows++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(int id); return {OPC, 5'd9, 17'(id)}; endfunction

  task automatic probe(input int id, output bit h, output bit s, output logic [4:0] b);
    @(negedge clk);
    instr_valid = 1; instr = word_of(id);
    #1;
    h = hit_o; s = stall_o; b = row_base_o;
    instr_valid = 0;
  endtask

  task automatic touch(input int id);
    @(negedge clk); instr_valid = 1; instr = word_of(id);
    @(negedge clk); instr_valid = 0;
  endtask

  task automatic load_op(input int id, input int exp_base, input bit chk_data);
    int cyc = 0;
    nlog = 0; nrows = 0;
    @(negedge clk);
    instr_valid = 1; instr = word_of(id);
    #1;
    chk(stall_o && !hit_o, "R3", "stall on miss", {stall_o, hit_o}, 2'b10);
    while (!(hit_o && !stall_o) && cyc < 20000) begin @(negedge clk); #1; cyc++; end
    chk(src_vec_o == vec_of(id), "R2", "source vector", src_vec_o, vec_of(id));
    chk(int'(row_base_o) == exp_base, "R6", "base row", row_base_o, exp_base);
    chk(dst_o == 5'd9, "R1", "destination field", dst_o, 9);
    instr_valid = 0;
    @(negedge clk); #1;
    chk(alog[0] == VTAB + 32'(4 * id), "R4", "table read", alog[0], VTAB + 32'(4 * id));
    chk(alog[1] == ptr_of(id) && alog[2] == ptr_of(id) + 4 && alog[3] == ptr_of(id) + 8,
        "R4", "image reads", alog[3], ptr_of(id) + 8);
    chk(nrows == int'(cnt_of(id)), "R5", "row count", nrows, cnt_of(id));
    chk(first_idx == exp_base && last_idx == exp_base + int'(cnt_of(id)) - 1,
        "R5", "row indices", last_idx, exp_base + int'(cnt_of(id)) - 1);
    if (chk_data) begin
      logic [ROW_BITS-1:0] e;
      e = exp_row(id, 0);
      chk(row0 == e, "R5", "row 0 low word", row0[31:0], e[31:0]);
      chk(row0[ROW_BITS-1 -: 10] == e[ROW_BITS-1 -: 10], "R5", "row 0 tail bits",
          32'(row0[ROW_BITS-1 -: 10]), 32'(e[ROW_BITS-1 -: 10]));
    end
  endtask

  task automatic t_reset;
    #1;
    chk(!stall_o && !hit_o && !exc_o && !row_we_o && !mem_req_o, "R9", "reset outputs",
        {stall_o, hit_o, exc_o, row_we_o, mem_req_o}, 0);
  endtask

  task automatic t_decode;
    bit h, s; logic [4:0] b;
    @(negedge clk); instr_valid = 1; instr = {10'h155, 5'd1, 17'd5}; #1;
    chk(!hit_o && !stall_o, "R1", "foreign opcode", {hit_o, stall_o}, 0);
    @(negedge clk); instr_valid = 0;
    chk(!mem_req_o, "R1", "foreign opcode no load", mem_req_o, 0);
    probe(5, h, s, b);
    chk(!h && s, "R9", "nothing resident after reset", {h, s}, 2'b01);
  endtask

  task automatic t_fill;
    bit h, s; logic [4:0] b;
    load_op(5, 0, 1);
    load_op(9, 4, 0);
    load_op(3, 14, 0);
    nlog = 0;
    touch(5);
    chk(nlog == 0, "R10", "resident id reads memory", nlog, 0);
    probe(9, h, s, b);
    chk(h && !s && b == 5'd4, "R2", "hit id 9", {h, s, 3'b0, b}, {2'b10, 3'b0, 5'd4});
  endtask

  task automatic t_lru;
    bit h, s; logic [4:0] b;
    load_op(7, 4, 0);
    probe(9, h, s, b);
    chk(!h, "R7", "least recent id 9 evicted", h, 0);
    probe(5, h, s, b);
    chk(h && b == 5'd0, "R7", "touched id 5 kept", {h, b}, {1'b1, 5'd0});
    probe(3, h, s, b);
    chk(h && b == 5'd14, "R7", "id 3 kept", {h, b}, {1'b1, 5'd14});
    load_op(2, 12, 0);
    probe(7, h, s, b);
    chk(h && b == 5'd4, "R6", "fitting load evicts nothing", {h, b}, {1'b1, 5'd4});
    load_op(4, 14, 0);
    probe(3, h, s, b);
    chk(!h, "R7", "oldest id 3 evicted", h, 0);
    probe(2, h, s, b);
    chk(h && b == 5'd12, "R7", "id 2 kept", {h, b}, {1'b1, 5'd12});
  endtask

  task automatic t_snoop;
    bit h, s; logic [4:0] b;
    @(negedge clk); snoop_valid = 1; snoop_addr = 32'h0008_0000;
    @(negedge clk); snoop_valid = 0; #1;
    chk(!exc_o, "R8", "outside store no exception", exc_o, 0);
    probe(5, h, s, b);
    chk(h, "R8", "outside store keeps entries", h, 1);
    @(negedge clk); snoop_valid = 1; snoop_addr = 32'h0001_2340;
    @(negedge clk); snoop_valid = 0; #1;
    chk(exc_o, "R8", "exception raised", exc_o, 1);
    @(negedge clk); #1;
    chk(!exc_o, "R8", "exception one cycle", exc_o, 0);
    probe(5, h, s, b);
    chk(!h && s, "R8", "id 5 flushed", {h, s}, 2'b01);
    probe(4, h, s, b);
    chk(!h, "R8", "id 4 flushed", h, 0);
  endtask

  initial begin
    fork
      begin
        t_reset;
        #23 rst_n = 1;
        t_decode;
        t_fill;
        t_lru;
        t_snoop;
      end
      begin
        repeat (100000) @(posedge clk);
        chk(0, "R3", "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule